// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer that steers a multicycle processor datapath. The datapath has one memory for instructions and data and one ALU. The sequencer runs four instruction kinds: load word, store word, register-register arithmetic and branch-if-equal. Each state lasts one clock cycle, so each instruction takes three to five cycles. In every cycle the block decodes the current state into a full set of datapath controls. In every cycle it also picks the next state from the 6-bit opcode held in the instruction register.

The sequence is built from these named states:
- Every instruction starts with FETCH and then DECODE.
- Load word runs MEM_ADDR, then MEM_LOAD, then LOAD_WB.
- Store word runs MEM_ADDR, then MEM_STORE.
- Register arithmetic runs R_EXEC, then R_DONE.
- Branch-if-equal runs BRANCH.
- After the last state of an instruction, the sequencer goes back to FETCH.
- An unsupported opcode goes back to FETCH directly after DECODE.

The state register is the only storage. The next-state logic and the output decode are purely combinational. The block folds the ALU zero flag into a single PC load enable.

Top module: `mcyc_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the sequencer in FETCH at that edge, from any state, including in the middle of an instruction.
- R2: In FETCH the outputs are as follows:
  - `mem_rd`=1, `addr_sel`=0, `ir_wr`=1.
  - `alu_a_sel`=0, `alu_b_sel`=01 (constant 4), `alu_cls`=00 (add).
  - `pc_wr`=1, `pc_src`=0 (ALU result), so `pc_load`=1.
  - Every other output is 0.
- R3: In DECODE, which always follows FETCH, `alu_a_sel`=0, `alu_b_sel`=11 (offset shifted left by 2) and `alu_cls`=00; every other output is 0.
- R4: In MEM_ADDR, `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended immediate) and `alu_cls`=00; every other output is 0.
- R5: In the memory-access states the ALU selects keep their MEM_ADDR values and `addr_sel`=1. MEM_LOAD drives `mem_rd`=1. MEM_STORE drives `mem_wr`=1.
- R6: In LOAD_WB, `reg_wr`=1, `dst_sel`=0 (rt field) and `wdata_sel`=1 (memory data). The ALU selects keep their MEM_ADDR values, and LOAD_WB is always entered directly from MEM_LOAD.
- R7: In R_EXEC, `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_cls`=10 (function field). R_DONE holds those ALU selects and drives `reg_wr`=1, `dst_sel`=1 (rd field) and `wdata_sel`=0 (ALU output).
- R8: BRANCH drives the following, and `pc_load` equals `alu_zero` during BRANCH:
  - `alu_a_sel`=1, `alu_b_sel`=00, `alu_cls`=01 (subtract).
  - `pc_wr_cond`=1, `pc_src`=1 (ALU output register), `pc_wr`=0.
- R9: After DECODE the opcode selects the path, and each instruction then returns to FETCH. The cycle counts are 5 for load, 4 for store, 4 for register arithmetic and 3 for branch.

  | Opcode | Instruction | Path after DECODE |
  |---|---|---|
  | 100011 | load word | MEM_ADDR |
  | 101011 | store word | MEM_ADDR |
  | 000000 | register arithmetic | R_EXEC |
  | 000100 | branch-if-equal | BRANCH |

  MEM_ADDR goes to MEM_STORE for 101011 and to MEM_LOAD otherwise.
- R10: Any other opcode returns to FETCH after DECODE, so the instruction takes 2 cycles and writes nothing.
- R11: Any output a state does not name is 0. `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result-is-zero flag |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write enable (data from register B) |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| ir_wr | output | 1 | Instruction register write enable |
| alu_a_sel | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 reg B, 01 four, 10 immediate, 11 offset<<2 |
| alu_cls | output | 2 | ALU class: 00 add, 01 subtract, 10 function field |
| reg_wr | output | 1 | Register file write enable |
| dst_sel | output | 1 | Destination register: 0 rt, 1 rd |
| wdata_sel | output | 1 | Register write data: 0 ALU output, 1 memory data |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write qualified by the zero flag |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALU output register |
| pc_load | output | 1 | Combined PC load enable |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of an instruction. The ports carry no state code, so the state can only be inferred from the control pattern. The stimulus first runs a register-arithmetic instruction through FETCH and DECODE. It raises `rst` in the R_EXEC cycle, then checks that the fetch pattern appears in the next cycle. It then checks that a following load runs its full five-cycle sequence. The branch is issued twice, with the zero flag low and then high, so that `pc_load` must follow the flag within BRANCH alone.

// File: rtl/mcyc_ctrl_pkg.sv
package mcyc_ctrl_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_RTYPE  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;

    typedef enum logic [3:0] {
        ST_FETCH     = 4'd0,
        ST_DECODE    = 4'd1,
        ST_MEM_ADDR  = 4'd2,
        ST_MEM_LOAD  = 4'd3,
        ST_MEM_STORE = 4'd4,
        ST_LOAD_WB   = 4'd5,
        ST_R_EXEC    = 4'd6,
        ST_R_DONE    = 4'd7,
        ST_BRANCH    = 4'd8
    } ctl_state_e;

    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_LOAD   = 3'd1,
        KIND_STORE  = 3'd2,
        KIND_RTYPE  = 3'd3,
        KIND_BRANCH = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        BSRC_REGB = 2'b00,
        BSRC_FOUR = 2'b01,
        BSRC_IMM  = 2'b10,
        BSRC_OFFS = 2'b11
    } bsrc_e;

    typedef enum logic [1:0] {
        ACLS_ADD  = 2'b00,
        ACLS_SUB  = 2'b01,
        ACLS_FUNC = 2'b10
    } acls_e;

    typedef struct packed {
        logic  mem_rd;
        logic  mem_wr;
        logic  addr_sel;
        logic  ir_wr;
        logic  a_sel;
        bsrc_e b_sel;
        acls_e alu_cls;
        logic  reg_wr;
        logic  dst_sel;
        logic  wdata_sel;
        logic  pc_wr;
        logic  pc_wr_cond;
        logic  pc_src;
    } ctl_word_t;

endpackage

// File: rtl/mcyc_op_decode.sv
module mcyc_op_decode
    import mcyc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_kind_e         kind
);

    always_comb begin
        unique case (opcode)
            OPC_LOAD:   kind = KIND_LOAD;
            OPC_STORE:  kind = KIND_STORE;
            OPC_RTYPE:  kind = KIND_RTYPE;
            OPC_BRANCH: kind = KIND_BRANCH;
            default:    kind = KIND_NONE;
        endcase
    end

endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
    import mcyc_ctrl_pkg::*;
(
    input  ctl_state_e cur,
    input  op_kind_e   kind,
    output ctl_state_e nxt
);

    always_comb begin
        unique case (cur)
            ST_FETCH: nxt = ST_DECODE;
            ST_DECODE: begin
                unique case (kind)
                    KIND_LOAD, KIND_STORE: nxt = ST_MEM_ADDR;
                    KIND_RTYPE:            nxt = ST_R_EXEC;
                    KIND_BRANCH:           nxt = ST_BRANCH;
                    default:               nxt = ST_FETCH;
                endcase
            end
            ST_MEM_ADDR:  nxt = (kind == KIND_STORE) ? ST_MEM_STORE : ST_MEM_LOAD;
            ST_MEM_LOAD:  nxt = ST_LOAD_WB;
            ST_MEM_STORE: nxt = ST_FETCH;
            ST_LOAD_WB:   nxt = ST_FETCH;
            ST_R_EXEC:    nxt = ST_R_DONE;
            ST_R_DONE:    nxt = ST_FETCH;
            ST_BRANCH:    nxt = ST_FETCH;
            default:      nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcyc_out_decode.sv
module mcyc_out_decode
    import mcyc_ctrl_pkg::*;
(
    input  ctl_state_e cur,
    output ctl_word_t  cw
);

    always_comb begin
        cw = '0;
        unique case (cur)
            ST_FETCH: begin
                cw.mem_rd  = 1'b1;
                cw.ir_wr   = 1'b1;
                cw.b_sel   = BSRC_FOUR;
                cw.alu_cls = ACLS_ADD;
                cw.pc_wr   = 1'b1;
            end
            ST_DECODE: begin
                cw.b_sel   = BSRC_OFFS;
                cw.alu_cls = ACLS_ADD;
            end
            ST_MEM_ADDR: begin
                cw.a_sel   = 1'b1;
                cw.b_sel   = BSRC_IMM;
            end
            ST_MEM_LOAD: begin
                cw.a_sel    = 1'b1;
                cw.b_sel    = BSRC_IMM;
                cw.addr_sel = 1'b1;
                cw.mem_rd   = 1'b1;
            end
            ST_MEM_STORE: begin
                cw.a_sel    = 1'b1;
                cw.b_sel    = BSRC_IMM;
                cw.addr_sel = 1'b1;
                cw.mem_wr   = 1'b1;
            end
            ST_LOAD_WB: begin
                cw.a_sel     = 1'b1;
                cw.b_sel     = BSRC_IMM;
                cw.reg_wr    = 1'b1;
                cw.wdata_sel = 1'b1;
            end
            ST_R_EXEC: begin
                cw.a_sel   = 1'b1;
                cw.b_sel   = BSRC_REGB;
                cw.alu_cls = ACLS_FUNC;
            end
            ST_R_DONE: begin
                cw.a_sel   = 1'b1;
                cw.b_sel   = BSRC_REGB;
                cw.alu_cls = ACLS_FUNC;
                cw.reg_wr  = 1'b1;
                cw.dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                cw.a_sel      = 1'b1;
                cw.b_sel      = BSRC_REGB;
                cw.alu_cls    = ACLS_SUB;
                cw.pc_wr_cond = 1'b1;
                cw.pc_src     = 1'b1;
            end
            default: cw = '0;
        endcase
    end

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_zero,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             addr_sel,
    output logic             ir_wr,
    output logic             alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic [1:0]       alu_cls,
    output logic             reg_wr,
    output logic             dst_sel,
    output logic             wdata_sel,
    output logic             pc_wr,
    output logic             pc_wr_cond,
    output logic             pc_src,
    output logic             pc_load
);

    ctl_state_e state_q;
    ctl_state_e state_d;
    op_kind_e   kind;
    ctl_word_t  cw;

    mcyc_op_decode u_opdec (
        .opcode (opcode),
        .kind   (kind)
    );

    mcyc_next_state u_next (
        .cur  (state_q),
        .kind (kind),
        .nxt  (state_d)
    );

    mcyc_out_decode u_outdec (
        .cur (state_q),
        .cw  (cw)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    assign mem_rd     = cw.mem_rd;
    assign mem_wr     = cw.mem_wr;
    assign addr_sel   = cw.addr_sel;
    assign ir_wr      = cw.ir_wr;
    assign alu_a_sel  = cw.a_sel;
    assign alu_b_sel  = cw.b_sel;
    assign alu_cls    = cw.alu_cls;
    assign reg_wr     = cw.reg_wr;
    assign dst_sel    = cw.dst_sel;
    assign wdata_sel  = cw.wdata_sel;
    assign pc_wr      = cw.pc_wr;
    assign pc_wr_cond = cw.pc_wr_cond;
    assign pc_src     = cw.pc_src;
    assign pc_load    = cw.pc_wr | (cw.pc_wr_cond & alu_zero);

endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       addr_sel,
    input logic       ir_wr,
    input logic [1:0] alu_b_sel,
    input logic       reg_wr,
    input logic       wdata_sel,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_load
);

    a_r1_reset_to_fetch: assert property (@(posedge clk)
        rst |=> (ir_wr && pc_wr && mem_rd));

    a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (alu_b_sel == 2'b11 && !mem_rd && !pc_wr && !ir_wr));

    a_r11_mem_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r5_store_address: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (addr_sel && !reg_wr));

    a_r6_wb_after_read: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && wdata_sel) |-> $past(mem_rd && addr_sel));

    a_r7_done_returns: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);

    a_r8_branch_returns: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_wr);

    a_r8_branch_gate: assert property (@(posedge clk) disable iff (rst)
        (pc_wr_cond && !alu_zero) |-> !pc_load);

endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .alu_zero   (alu_zero),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .addr_sel   (addr_sel),
    .ir_wr      (ir_wr),
    .alu_b_sel  (alu_b_sel),
    .reg_wr     (reg_wr),
    .wdata_sel  (wdata_sel),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_load    (pc_load)
);

// File: tb/mcyc_ctrl_test.sv
module mcyc_ctrl_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'b000000;
    logic       alu_zero = 1'b0;
    logic mem_rd, mem_wr, addr_sel, ir_wr, alu_a_sel, reg_wr, dst_sel, wdata_sel;
    logic pc_wr, pc_wr_cond, pc_src, pc_load;
    logic [1:0] alu_b_sel, alu_cls;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] w;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    mcyc_ctrl uut (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel), .ir_wr(ir_wr),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_cls(alu_cls),
        .reg_wr(reg_wr), .dst_sel(dst_sel), .wdata_sel(wdata_sel),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .pc_load(pc_load)
    );

    wire [15:0] act = {mem_rd, mem_wr, addr_sel, ir_wr, alu_a_sel, alu_b_sel, alu_cls,
                       reg_wr, dst_sel, wdata_sel, pc_wr, pc_wr_cond, pc_src, pc_load};

    function automatic logic [15:0] mk(input logic mrd, mwr, asel, irw, a,
                                       input logic [1:0] b, c,
                                       input logic rw, dst, wd, pw, pwc, ps, pl);
        return {mrd, mwr, asel, irw, a, b, c, rw, dst, wd, pw, pwc, ps, pl};
    endfunction

    localparam logic [15:0] W_FETCH  = {1'b1,1'b0,1'b0,1'b1,1'b0,2'b01,2'b00,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1};
    localparam logic [15:0] W_DECODE = {1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0};

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic push(input logic [15:0] w, input string tag);
        exp_t e;
        e.w = w;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: pops one expected control word per cycle, mid-cycle
    always @(negedge clk) begin
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(act, e.w, e.tag);
        end
    end

    // Driver: called in the FETCH cycle, just after the rising edge
    task automatic issue(input logic [5:0] op, input logic z);
        int n;
        opcode = op;
        alu_zero = z;
        push(W_FETCH, "R2");
        push(W_DECODE, "R3 R11");
        case (op)
            6'b100011: begin
                push(mk(0,0,0,0,1,2'b10,2'b00,0,0,0,0,0,0,0), "R9 R4");
                push(mk(1,0,1,0,1,2'b10,2'b00,0,0,0,0,0,0,0), "R5 load");
                push(mk(0,0,0,0,1,2'b10,2'b00,1,0,1,0,0,0,0), "R6");
                n = 5;
            end
            6'b101011: begin
                push(mk(0,0,0,0,1,2'b10,2'b00,0,0,0,0,0,0,0), "R9 R4");
                push(mk(0,1,1,0,1,2'b10,2'b00,0,0,0,0,0,0,0), "R5 store");
                n = 4;
            end
            6'b000000: begin
                push(mk(0,0,0,0,1,2'b00,2'b10,0,0,0,0,0,0,0), "R9 R7 exec");
                push(mk(0,0,0,0,1,2'b00,2'b10,1,1,0,0,0,0,0), "R7 done");
                n = 4;
            end
            6'b000100: begin
                push(mk(0,0,0,0,1,2'b00,2'b01,0,0,0,0,1,1,z), "R9 R8");
                n = 3;
            end
            default: n = 2;
        endcase
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic reset_check(input string tag);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(act, W_FETCH, tag);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        reset_check("R1 reset state");

        issue(6'b100011, 1'b0);
        issue(6'b101011, 1'b1);
        issue(6'b000000, 1'b1);
        issue(6'b000100, 1'b0);
        issue(6'b000100, 1'b1);
        issue(6'b001000, 1'b0);   // R10: unsupported opcode
        issue(6'b111111, 1'b1);   // R10: unsupported opcode

        // R1: reset in the middle of a register-arithmetic instruction
        opcode = 6'b000000;
        push(W_FETCH, "R2");
        push(W_DECODE, "R3");
        repeat (2) @(posedge clk);
        #1;
        reset_check("R1 mid-instruction");

        issue(6'b100011, 1'b1);
        issue(6'b000000, 1'b0);
        issue(6'b101011, 1'b0);

        @(negedge clk);
        check(act, W_FETCH, "R9 return to fetch");
        n_run++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R9: %0d expected cycles left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule